// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block recovers one 128-bit plaintext block from a 128-bit ciphertext block under AES-128. It does not expand keys itself. Instead it drives a round-number output that addresses an external bank of eleven precomputed encryption round keys, and it expects the addressed key on its key input in the same cycle. Keys are consumed from the last encryption round key down to the cipher key. The inverse round transformations are applied in the reverse of the encryption order. Key addition is the same bitwise XOR that encryption uses.

The datapath keeps a single 128-bit state register and works through each round in three registered steps: inverse row rotation with inverse byte substitution, then key addition, then inverse column mixing. The initial key addition takes one cycle and the last round has no column mixing, so a block always completes in a fixed thirty cycles. A start pulse seen while idle loads the ciphertext. A start pulse seen while a block is in progress is dropped. The result sits on the plaintext output and is marked by a one-cycle done pulse. It stays there until the next block completes.

Top module: `aes_inv_core`

## Requirements
- R1: For any key whose expanded schedule is held in the external bank (entry n holding encryption round key n), the plaintext output equals the AES-128 inverse cipher of the loaded ciphertext. For example, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a under key 000102030405060708090a0b0c0d0e0f gives 00112233445566778899aabbccddeeff. Byte 0 of the state is bits [127:120], and bytes fill columns first.
- R2: The done output rises exactly 30 rising edges after the edge that accepts a start, counting that edge as the first.
- R3: While idle, the round index output is 10. After an accepted start at edge 0, the index after edge k (k from 0 to 28) is 9 − k/3 (integer division) for k ≤ 27, and 0 for k = 28. It returns to 10 when done rises.
- R4: Done is high for exactly one cycle per block.
- R5: A start asserted while a block is in progress is ignored. The round index sequence, the completion time and the result of the running block are unchanged.
- R6: A start asserted in the same cycle that done is high is accepted and begins a new block.
- R7: The plaintext output changes only in the cycle that done rises, and otherwise holds the last result.
- R8: After reset, done is 0, the plaintext output is all zeros and the round index is 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin decrypting `ct_in` when idle |
| ct_in | input | 128 | Ciphertext block, sampled on the accepting edge |
| round_idx | output | 4 | Address of the round key required this cycle |
| rk_in | input | 128 | Round key addressed by `round_idx` |
| pt_out | output | 128 | Last completed plaintext block |
| done | output | 1 | One-cycle pulse marking a new `pt_out` |

## Verification
Two events can coincide at the end of a block: the completion pulse, and the acceptance of a new start, because the core turns idle in the same cycle it raises done. The bench provokes this by asserting the next start, with a fresh key bank and ciphertext, in exactly the cycle done is high. It then judges both blocks: the first result must stay on the output and the second must arrive with its round index sequence and its thirty-cycle latency intact. Separately, a start injected in the middle of a block must leave that block's index sequence, latency and result untouched.

// File: rtl/aes_inv_pkg.sv
`timescale 1ns/1ps
package aes_inv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SUB,
        PH_ARK,
        PH_MIX
    } phase_e;

    // Multiply in GF(2^8) modulo x^8 + x^4 + x^3 + x + 1
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // x^254 is the multiplicative inverse (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] pw;
        logic [7:0] r;
        pw = x;
        r  = 8'h01;
        for (int k = 1; k < 8; k++) begin
            pw = gf_mul(pw, pw);
            r  = gf_mul(r, pw);
        end
        return r;
    endfunction

    // Undo the affine map of the forward substitution, then invert
    function automatic logic [7:0] inv_sub(input logic [7:0] s);
        logic [7:0] u;
        u = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
        return gf_inv(u);
    endfunction

endpackage

// File: rtl/aes_inv_shiftsub.sv
`timescale 1ns/1ps
module aes_inv_shiftsub
    import aes_inv_pkg::*;
#(
    parameter int NROW = 4,
    parameter int NCOL = 4,
    localparam int W   = 8 * NROW * NCOL
) (
    input  logic [W-1:0] state_i,
    output logic [W-1:0] state_o
);
    // Right rotation of row r by r positions, then inverse substitution
    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            localparam int DST = r + NROW * c;
            localparam int SRC = r + NROW * ((c - r + NCOL) % NCOL);
            assign state_o[W-1-8*DST -: 8] = inv_sub(state_i[W-1-8*SRC -: 8]);
        end
    end
endmodule

// File: rtl/aes_inv_mix.sv
`timescale 1ns/1ps
module aes_inv_mix
    import aes_inv_pkg::*;
#(
    parameter int NCOL = 4,
    localparam int W   = 32 * NCOL
) (
    input  logic [W-1:0] state_i,
    output logic [W-1:0] state_o
);
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [7:0] a0, a1, a2, a3;
        assign a0 = state_i[W-1-32*c      -: 8];
        assign a1 = state_i[W-1-32*c - 8  -: 8];
        assign a2 = state_i[W-1-32*c - 16 -: 8];
        assign a3 = state_i[W-1-32*c - 24 -: 8];
        assign state_o[W-1-32*c -: 8] =
            gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
        assign state_o[W-1-32*c - 8 -: 8] =
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
        assign state_o[W-1-32*c - 16 -: 8] =
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
        assign state_o[W-1-32*c - 24 -: 8] =
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    end
endmodule

// File: rtl/aes_inv_core.sv
`timescale 1ns/1ps
module aes_inv_core
    import aes_inv_pkg::*;
#(
    parameter int NR    = 10,
    localparam int RW   = $clog2(NR + 1),
    localparam int BW   = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [BW-1:0] ct_in,
    output logic [RW-1:0] round_idx,
    input  logic [BW-1:0] rk_in,
    output logic [BW-1:0] pt_out,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        logic [RW-1:0] rnd;
        logic [BW-1:0] st;
        logic [BW-1:0] pt;
        logic          done;
    } core_t;

    core_t q, d;
    logic [BW-1:0] ss_out;
    logic [BW-1:0] mx_out;
    logic          busy;

    aes_inv_shiftsub #(.NROW(4), .NCOL(4)) u_shiftsub (
        .state_i (q.st),
        .state_o (ss_out)
    );

    aes_inv_mix #(.NCOL(4)) u_mix (
        .state_i (q.st),
        .state_o (mx_out)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.st    = ct_in ^ rk_in;
                    d.rnd   = RW'(NR - 1);
                    d.phase = PH_SUB;
                end
            end
            PH_SUB: begin
                d.st    = ss_out;
                d.phase = PH_ARK;
            end
            PH_ARK: begin
                if (q.rnd == '0) begin
                    d.pt    = q.st ^ rk_in;
                    d.done  = 1'b1;
                    d.rnd   = RW'(NR);
                    d.phase = PH_IDLE;
                end else begin
                    d.st    = q.st ^ rk_in;
                    d.phase = PH_MIX;
                end
            end
            PH_MIX: begin
                d.st    = mx_out;
                d.rnd   = q.rnd - 1'b1;
                d.phase = PH_SUB;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.phase <= PH_IDLE;
            q.rnd   <= RW'(NR);
            q.st    <= '0;
            q.pt    <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.phase != PH_IDLE);
    assign round_idx = q.rnd;
    assign pt_out    = q.pt;
    assign done      = q.done;

endmodule

// File: rtl/aes_inv_core_chk.sv
`timescale 1ns/1ps
module aes_inv_core_chk #(
    parameter int NR  = 10,
    localparam int RW = $clog2(NR + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [RW-1:0] round_idx,
    input logic [127:0]  pt_out
);
    localparam int LAT = 3 * NR;
    localparam int CW  = $clog2(LAT + 2);

    logic [CW-1:0] since_start;

    always_ff @(posedge clk) begin
        if (rst)                  since_start <= '0;
        else if (start && !busy)  since_start <= CW'(1);
        else if (done)            since_start <= '0;
        else if (since_start != '0) since_start <= since_start + 1'b1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> since_start == CW'(LAT));

    assert_idle_index_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> round_idx == RW'(NR));

    assert_first_index_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> round_idx == RW'(NR - 1));

    assert_busy_index_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> round_idx < RW'(NR));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(pt_out));

endmodule

bind aes_inv_core aes_inv_core_chk #(.NR(NR)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .round_idx (round_idx),
    .pt_out    (pt_out)
);

// File: tb/aes_inv_core_tb_top.sv
`timescale 1ns/1ps
module aes_inv_core_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] ct_in;
    logic [3:0]   round_idx;
    logic [127:0] rk_in;
    logic [127:0] pt_out;
    logic         done;

    logic [127:0] bank [0:15];
    int nchk  = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign rk_in = bank[round_idx];

    aes_inv_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ct_in     (ct_in),
        .round_idx (round_idx),
        .rk_in     (rk_in),
        .pt_out    (pt_out),
        .done      (done)
    );

    // ---------------- reference forward cipher ----------------
    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p, s;
        p = 0; s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= s;
            s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [7:0] fsub(input logic [7:0] x);
        logic [7:0] y, pw;
        y = 8'h01; pw = x;
        for (int k = 1; k < 8; k++) begin
            pw = fmul(pw, pw);
            y  = fmul(y, pw);
        end
        return y ^ {y[6:0], y[7]} ^ {y[5:0], y[7:6]} ^ {y[4:0], y[7:5]} ^ {y[3:0], y[7:4]} ^ 8'h63;
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [0:43];
        logic [31:0] t;
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {fsub(t[31:24]), fsub(t[23:16]), fsub(t[15:8]), fsub(t[7:0])} ^ {rc, 24'h0};
                rc = fmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 16; r++) bank[r] = '0;
        for (int r = 0; r < 11; r++) bank[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] encrypt(input logic [127:0] p);
        logic [7:0]   a [0:15];
        logic [7:0]   b [0:15];
        logic [127:0] st;
        st = p ^ bank[0];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) a[i] = fsub(st[127-8*i -: 8]);
            for (int row = 0; row < 4; row++)
                for (int c = 0; c < 4; c++) b[row+4*c] = a[row + 4*((c+row)%4)];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a[4*c]   = fmul(b[4*c],8'h02) ^ fmul(b[4*c+1],8'h03) ^ b[4*c+2] ^ b[4*c+3];
                    a[4*c+1] = b[4*c] ^ fmul(b[4*c+1],8'h02) ^ fmul(b[4*c+2],8'h03) ^ b[4*c+3];
                    a[4*c+2] = b[4*c] ^ b[4*c+1] ^ fmul(b[4*c+2],8'h02) ^ fmul(b[4*c+3],8'h03);
                    a[4*c+3] = fmul(b[4*c],8'h03) ^ b[4*c+1] ^ b[4*c+2] ^ fmul(b[4*c+3],8'h02);
                end
                for (int i = 0; i < 16; i++) b[i] = a[i];
            end
            for (int i = 0; i < 16; i++) st[127-8*i -: 8] = b[i];
            st = st ^ bank[r];
        end
        return st;
    endfunction

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] rand128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Starts a block in the current cycle; returns in the cycle done is high
    // when chain is set, else after checking the cycles that follow.
    task automatic run_block(input logic [127:0] key, input logic [127:0] ptx,
                             input bit poke, input bit chain, input string tag);
        logic [127:0] ct;
        int expr;
        expand(key);
        ct    = encrypt(ptx);
        ct_in = ct;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (k < 29) begin
                expr = (k >= 27) ? 0 : 9 - k / 3;
                check(done == 1'b0, "R2", 128'(done), 128'(0));
                check(round_idx == 4'(expr), poke ? "R5" : "R3", 128'(round_idx), 128'(expr));
                if (poke && k == 10) begin start = 1'b1; ct_in = ~ct; end
                if (poke && k == 11) start = 1'b0;
                @(posedge clk); #1;
            end else begin
                check(done == 1'b1, "R2", 128'(done), 128'(1));
                check(round_idx == 4'd10, "R3", 128'(round_idx), 128'(10));
                check(pt_out == ptx, tag, pt_out, ptx);
            end
        end
        if (!chain) begin
            @(posedge clk); #1;
            check(done == 1'b0, "R4", 128'(done), 128'(0));
            check(pt_out == ptx, "R7", pt_out, ptx);
            ct_in = rand128();
            repeat (3) begin @(posedge clk); #1; end
            check(pt_out == ptx, "R7", pt_out, ptx);
            check(round_idx == 4'd10, "R3", 128'(round_idx), 128'(10));
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [127:0] key0, pt0, ct0;
        void'($urandom(32'h5eed_a11e));
        rst = 1'b1; start = 1'b0; ct_in = '0;
        for (int r = 0; r < 16; r++) bank[r] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check(done == 1'b0, "R8", 128'(done), 128'(0));
        check(pt_out == '0, "R8", pt_out, 128'(0));
        check(round_idx == 4'd10, "R8", 128'(round_idx), 128'(10));
        rst = 1'b0;
        @(posedge clk); #1;

        // R1: known vector, bench model cross-checked first
        key0 = 128'h000102030405060708090a0b0c0d0e0f;
        pt0  = 128'h00112233445566778899aabbccddeeff;
        expand(key0);
        ct0 = encrypt(pt0);
        check(ct0 == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1", ct0,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_block(key0, pt0, 1'b0, 1'b0, "R1");

        // R5: start while busy is ignored
        run_block(rand128(), rand128(), 1'b1, 1'b0, "R5");

        // R6: start in the done cycle is accepted
        run_block(rand128(), rand128(), 1'b0, 1'b1, "R6");
        run_block(rand128(), rand128(), 1'b0, 1'b0, "R6");

        // Corner keys and data
        run_block('0, '0, 1'b0, 1'b0, "R1");
        run_block('1, '1, 1'b0, 1'b0, "R1");

        // Random mix of plain, poked and chained blocks
        for (int n = 0; n < 24; n++) begin
            bit pk, ch;
            pk = ($urandom() % 3) == 0;
            ch = ($urandom() % 3) == 0;
            run_block(rand128(), rand128(), pk, ch, ch ? "R6" : (pk ? "R5" : "R1"));
            if (!ch && ($urandom() % 2)) begin
                repeat (1 + $urandom() % 4) begin @(posedge clk); #1; end
            end
        end
        run_block(rand128(), rand128(), 1'b0, 1'b0, "R1");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule